// File: doc/BRIEF.md
# Dual-Read Single-Write Register File

This block is the general-purpose register store of a small single-cycle integer datapath. It holds 32 entries of 32 bits each. Two read ports, each steered by its own 5-bit index, return the selected entry combinationally, so operands are ready in the same cycle that their indices arrive. One write port takes a 5-bit index, a 32-bit value and an enable.

Writes commit on the falling clock edge. In a single-cycle datapath, the result computed in the first half of a cycle is therefore stored at mid-cycle. It can be read back before the next rising edge, which needs no forwarding path. Entry zero is wired to zero: it always reads zero and drops any write aimed at it. An active-high reset, sampled on the same falling edge, clears all entries.

Top module: `dual_read_regfile`

## Requirements
- R1: After reset, every entry reads 0 on both read ports.
- R2: When `wr_en` is 1 at a falling clock edge, the entry selected by `wr_idx` takes `wr_data` at that edge and holds it, and it reads back on the following rising edge.
- R3: When `wr_en` is 0 at a falling edge, no entry changes.
- R4: Index 0 always reads 0 on either port, including right after a write of a nonzero value to index 0.
- R5: The two read ports are independent. `rd_data_a` shows the entry at `rd_idx_a` and `rd_data_b` shows the entry at `rd_idx_b`, with no added latency.
- R6: When both read indices are equal, both ports return the same value.
- R7: A read of the entry being written shows the old value before the falling edge and the new value after it, within the same clock period.
- R8: A write changes only the entry selected by `wr_idx`. All other entries keep their values.
- R9: When `rst` and `wr_en` are both 1 at a falling edge, reset wins and the targeted entry reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Storage updates on its falling edge |
| rst | input | 1 | Synchronous active-high clear, sampled on the falling edge |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Entry selected for writing |
| wr_data | input | 32 | Value to write |
| rd_idx_a | input | 5 | Entry selected for read port A |
| rd_data_a | output | 32 | Contents of entry `rd_idx_a` |
| rd_idx_b | input | 5 | Entry selected for read port B |
| rd_data_b | output | 32 | Contents of entry `rd_idx_b` |

## Verification
Two functions can fall in the same clock period: a write to an entry, and a combinational read of that same entry. The bench provokes this by issuing the write just after a rising edge while a read port already points at the target entry. It samples that port twice in the same period: once before the falling edge, where the old value is expected, and once after it, where the new value must already appear before the next rising edge. A second overlap, a reset and a write on the same falling edge, is driven as well and judged by reading the target entry back as zero.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int unsigned RF_DEPTH = 32;
    localparam int unsigned RF_WIDTH = 32;
endpackage

// File: rtl/rf_wr_decode.sv
// Turns the write index and enable into one strobe per entry.
// Entry zero never receives a strobe, so writes to it are dropped.
module rf_wr_decode #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [DEPTH-1:0] strobe
);
    for (genvar e = 0; e < DEPTH; e++) begin : g_strobe
        if (e == 0) begin : g_zero
            assign strobe[e] = 1'b0;
        end else begin : g_live
            assign strobe[e] = wr_en && (wr_idx == IDX_W'(e));
        end
    end
endmodule

// File: rtl/rf_storage.sv
// Entry array. Live entries update on the falling clock edge;
// entry zero is a constant.
module rf_storage #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DEPTH-1:0]             strobe,
    input  logic [WIDTH-1:0]             wr_data,
    output logic [DEPTH-1:0][WIDTH-1:0]  contents
);
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        if (e == 0) begin : g_const
            assign contents[e] = '0;
        end else begin : g_flop
            logic [WIDTH-1:0] value_q;
            always_ff @(negedge clk) begin
                if (rst) begin
                    value_q <= '0;
                end else if (strobe[e]) begin
                    value_q <= wr_data;
                end
            end
            assign contents[e] = value_q;
        end
    end
endmodule

// File: rtl/rf_read_mux.sv
// Combinational selector for one read port.
module rf_read_mux #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] contents,
    input  logic [IDX_W-1:0]            idx,
    output logic [WIDTH-1:0]            data
);
    always_comb begin
        data = contents[idx];
    end
endmodule

// File: rtl/dual_read_regfile.sv
module dual_read_regfile #(
    parameter int unsigned DEPTH = rf_pkg::RF_DEPTH,
    parameter int unsigned WIDTH = rf_pkg::RF_WIDTH,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [WIDTH-1:0] rd_data_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [WIDTH-1:0] rd_data_b
);
    logic [DEPTH-1:0]            strobe;
    logic [DEPTH-1:0][WIDTH-1:0] contents;

    rf_wr_decode #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_decode (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .strobe (strobe)
    );

    rf_storage #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_storage (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .wr_data  (wr_data),
        .contents (contents)
    );

    rf_read_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_read_a (
        .contents (contents),
        .idx      (rd_idx_a),
        .data     (rd_data_a)
    );

    rf_read_mux #(.DEPTH(DEPTH), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_read_b (
        .contents (contents),
        .idx      (rd_idx_b),
        .data     (rd_data_b)
    );
endmodule

// File: rtl/dual_read_regfile_checker.sv
module dual_read_regfile_checker #(
    parameter int unsigned WIDTH = 32,
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [WIDTH-1:0] wr_data,
    input logic [IDX_W-1:0] rd_idx_a,
    input logic [WIDTH-1:0] rd_data_a,
    input logic [IDX_W-1:0] rd_idx_b,
    input logic [WIDTH-1:0] rd_data_b
);
    // Record what the most recent falling edge did.
    logic             last_wr_live = 1'b0;
    logic [IDX_W-1:0] last_wr_idx  = '0;
    logic [WIDTH-1:0] last_wr_val  = '0;
    logic             touched      = 1'b1;

    always_ff @(negedge clk) begin
        last_wr_live <= !rst && wr_en && (wr_idx != '0);
        last_wr_idx  <= wr_idx;
        last_wr_val  <= wr_data;
        touched      <= rst || wr_en;
    end

    // R2: a write committed at the falling edge reads back at the next rising edge
    a_r2_write_visible: assert property (@(posedge clk) disable iff (rst)
        (last_wr_live && rd_idx_a == last_wr_idx) |-> (rd_data_a == last_wr_val));

    // R3: with no write and no reset in between, an unchanged index reads an unchanged value
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!touched && $stable(rd_idx_a)) |-> $stable(rd_data_a));

    // R4: index zero reads zero on both ports
    a_r4_zero_a: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == '0) |-> (rd_data_a == '0));
    a_r4_zero_b: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_b == '0) |-> (rd_data_b == '0));

    // R6: equal indices give equal data
    a_r6_same_idx: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b));
endmodule

bind dual_read_regfile dual_read_regfile_checker #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/dual_read_regfile_bench.sv
module dual_read_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx_a = '0;
    logic [31:0] rd_data_a;
    logic [4:0]  rd_idx_b = '0;
    logic [31:0] rd_data_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dual_read_regfile u_dual_read_regfile (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx_a  (rd_idx_a),
        .rd_data_a (rd_data_a),
        .rd_idx_b  (rd_idx_b),
        .rd_data_b (rd_data_b)
    );

    function automatic logic [31:0] pattern(int i);
        return 32'hA500_0000 ^ (32'(i) * 32'h0101_0103);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read both ports combinationally, away from any edge.
    task automatic read_pair(logic [4:0] a, logic [4:0] b);
        rd_idx_a = a;
        rd_idx_b = b;
        #1;
    endtask

    // Present a write after a rising edge; it lands on the next falling edge.
    task automatic write_entry(logic [4:0] idx, logic [31:0] val);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_idx = idx; wr_data = val;
        @(negedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst = 1'b1;
        @(negedge clk); @(negedge clk); #2;
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < 32; i++) begin
            read_pair(5'(i), 5'(31 - i));
            check("R1 port A after reset", rd_data_a, 32'h0);
            check("R1 port B after reset", rd_data_b, 32'h0);
        end
    endtask

    task automatic t_fill_and_read();
        for (int i = 1; i < 32; i++) write_entry(5'(i), pattern(i));
        @(posedge clk); #2;
        for (int i = 1; i < 32; i++) begin
            read_pair(5'(i), 5'(32 - i));
            check("R2 stored value port A", rd_data_a, pattern(i));
            check("R5 independent port B", rd_data_b, pattern(32 - i));
        end
    endtask

    task automatic t_zero_entry();
        write_entry(5'd0, 32'hDEAD_BEEF);
        @(posedge clk); #2;
        read_pair(5'd0, 5'd0);
        check("R4 index zero port A", rd_data_a, 32'h0);
        check("R4 index zero port B", rd_data_b, 32'h0);
    endtask

    task automatic t_disabled_write();
        @(posedge clk); #2;
        wr_en = 1'b0; wr_idx = 5'd9; wr_data = 32'h1234_5678;
        @(negedge clk); #2;
        @(posedge clk); #2;
        read_pair(5'd9, 5'd9);
        check("R3 disabled write ignored", rd_data_a, pattern(9));
        check("R6 same index both ports", rd_data_b, rd_data_a);
    endtask

    task automatic t_neighbours();
        write_entry(5'd16, 32'h0F0F_F0F0);
        read_pair(5'd15, 5'd17);
        check("R8 lower neighbour kept", rd_data_a, pattern(15));
        check("R8 upper neighbour kept", rd_data_b, pattern(17));
        read_pair(5'd16, 5'd16);
        check("R8 target updated", rd_data_a, 32'h0F0F_F0F0);
        check("R6 same index both ports", rd_data_b, 32'h0F0F_F0F0);
    endtask

    task automatic t_same_cycle();
        @(posedge clk); #2;
        wr_en = 1'b1; wr_idx = 5'd7; wr_data = 32'hCAFE_0007;
        read_pair(5'd7, 5'd8);
        check("R7 old value before falling edge", rd_data_a, pattern(7));
        @(negedge clk); #1;
        check("R7 new value after falling edge", rd_data_a, 32'hCAFE_0007);
        check("R8 other port untouched", rd_data_b, pattern(8));
        wr_en = 1'b0;
        @(posedge clk); #2;
        check("R2 value at rising edge", rd_data_a, 32'hCAFE_0007);
    endtask

    task automatic t_reset_vs_write();
        @(posedge clk); #2;
        rst = 1'b1; wr_en = 1'b1; wr_idx = 5'd20; wr_data = 32'h5555_AAAA;
        @(negedge clk); #2;
        rst = 1'b0; wr_en = 1'b0;
        read_pair(5'd20, 5'd3);
        check("R9 reset beats write", rd_data_a, 32'h0);
        check("R1 reset clears others", rd_data_b, 32'h0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_fill_and_read();
        t_zero_entry();
        t_disabled_write();
        t_neighbours();
        t_same_cycle();
        t_reset_vs_write();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule